// File: doc/BRIEF.md
# Hardware Loop Replay Stack

This unit sits between the instruction decoder and the execute stage and gives the front end loops that cost nothing to repeat. It does not decode relative jump targets. When a loop-begin instruction arrives, it pushes the address of the first body instruction onto a small stack. For a loop that can be left early, it also pushes the exit address. While the body runs for the first time, the unit captures the first few decoded body instructions next to that stack entry.

When a loop-back instruction arrives, the captured instructions are sent out at once on a replay port. In the same cycle, fetch is redirected past them, to the loop start plus the byte span of the captured instructions. The decoder's pipeline therefore never drains. A break pops the innermost loop and steers fetch to its recorded exit address. A normal exit pops the loop and lets fetch continue in sequence. Overflow, underflow and a break from a loop with no recorded exit each raise a one-cycle flag.

Top module: `loop_track_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it with no input, every valid and flag output is 0 and every data output is zero.
- R2: A valid instruction of kind 0 (normal) appears on out_valid/out_pc/out_instr one cycle after it is presented. In any cycle that carries no such result, all output fields read zero.
- R3: The kind encoding is 1 loop-begin, 2 loop-begin with exit address, 3 loop-back, 4 normal exit and 5 break. A loop-begin is not forwarded on out_valid. If the stack is not full, it pushes a start address equal to in_pc + in_len. Kind 2 also records in_end as the exit address.
- R4: After a push, the next normal instructions are captured for that loop, up to CACHE of them, together with the sum of their lengths. Any control instruction (kinds 1 to 5) ends capture for the innermost loop.
- R5: A loop-back with a non-empty stack produces the following one cycle later. rpl_count equals the number captured. rpl_instr holds slot j at bits [j*IW +: IW], in capture order, and slots not filled read zero. rpl_pc equals the loop start. redir_valid is 1 with redir_pc = start + captured span. The entry stays on the stack.
- R6: A break on a loop that has an exit address pops it, and one cycle later asserts redir_valid with redir_pc equal to that address.
- R7: A break on a loop without an exit address pops it and asserts brk_err one cycle later, with no redirect.
- R8: A normal exit pops the innermost loop and produces no redirect and no output.
- R9: A loop-begin while DEPTH loops are active raises ovf_flag one cycle later and leaves the stack contents unchanged.
- R10: A loop-back, exit or break with an empty stack raises udf_flag one cycle later and has no other effect.
- R11: Popping an inner loop exposes the enclosing loop with its start address and captured instructions intact.
- R12: In any cycle at most one of out_valid, redir_valid, ovf_flag, udf_flag and brk_err is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_kind | input | 3 | Instruction class (see R3) |
| in_pc | input | AW | Byte address of the instruction |
| in_len | input | LW | Instruction length in bytes |
| in_instr | input | IW | Decoded instruction word |
| in_end | input | AW | Loop exit address for kind 2 |
| out_valid | output | 1 | Forwarded normal instruction valid |
| out_pc | output | AW | Address of the forwarded instruction |
| out_instr | output | IW | Forwarded instruction |
| rpl_count | output | CW | Number of replayed instructions |
| rpl_pc | output | AW | Address of the first replayed instruction |
| rpl_instr | output | CACHE*IW | Replayed instructions, slot 0 lowest |
| redir_valid | output | 1 | Fetch redirect request |
| redir_pc | output | AW | Fetch redirect address |
| ovf_flag | output | 1 | Push beyond stack depth |
| udf_flag | output | 1 | Pop or loop-back on an empty stack |
| brk_err | output | 1 | Break from a loop with no exit address |

## Verification
A loop body longer than the capture window shows that capture stops at CACHE entries and that the redirect skips exactly the captured bytes. A single-instruction body shows that capture closes early and that empty slots read zero. Nested loops, with a break out of the inner one, separate per-level capture storage from a shared one. They also show that a break without an exit address is flagged rather than redirected. Filling the stack past DEPTH, draining it past empty, and running a loop that sits at the top of the 40-bit address range exercise the edges of the pointer and the width of the address arithmetic.

// File: rtl/loop_track_pkg.sv
`timescale 1ns/1ps
package loop_track_pkg;
  typedef enum logic [2:0] {
    LK_NORM    = 3'd0,
    LK_BEGIN   = 3'd1,
    LK_BEGIN_X = 3'd2,
    LK_BACK    = 3'd3,
    LK_EXIT    = 3'd4,
    LK_BREAK   = 3'd5
  } lk_kind_e;
endpackage

// File: rtl/loop_addr_stack.sv
`timescale 1ns/1ps
module loop_addr_stack #(
  parameter int AW    = 40,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int IXW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic           pop,
  input  logic [AW-1:0]  push_start,
  input  logic [AW-1:0]  push_end,
  input  logic           push_has_end,
  output logic [AW-1:0]  top_start,
  output logic [AW-1:0]  top_end,
  output logic           top_has_end,
  output logic [PW-1:0]  level,
  output logic [IXW-1:0] top_idx,
  output logic [IXW-1:0] new_idx,
  output logic           full,
  output logic           empty
);
  logic [AW-1:0]    start_mem [DEPTH];
  logic [AW-1:0]    end_mem   [DEPTH];
  logic [DEPTH-1:0] has_mem;

  assign full    = (level == PW'(DEPTH));
  assign empty   = (level == '0);
  assign new_idx = IXW'(level);
  assign top_idx = IXW'(level - PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (push && !full) begin
      level <= level + PW'(1);
    end else if (pop && !empty) begin
      level <= level - PW'(1);
    end
  end

  // storage without reset so it can map onto memory
  always_ff @(posedge clk) begin
    if (push && !full) begin
      start_mem[new_idx] <= push_start;
      end_mem[new_idx]   <= push_end;
      has_mem[new_idx]   <= push_has_end;
    end
  end

  assign top_start   = start_mem[top_idx];
  assign top_end     = end_mem[top_idx];
  assign top_has_end = has_mem[top_idx];
endmodule

// File: rtl/loop_instr_cache.sv
`timescale 1ns/1ps
module loop_instr_cache #(
  parameter int IW    = 32,
  parameter int LW    = 3,
  parameter int DEPTH = 4,
  parameter int CACHE = 2,
  localparam int IXW  = $clog2(DEPTH),
  localparam int CW   = $clog2(CACHE + 1),
  localparam int SLW  = $clog2(CACHE),
  localparam int SPW  = LW + CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic [IXW-1:0]    init_idx,
  input  logic              close,
  input  logic [IXW-1:0]    close_idx,
  input  logic              wr,
  input  logic [IXW-1:0]    wr_idx,
  input  logic [IW-1:0]     wr_data,
  input  logic [LW-1:0]     wr_len,
  input  logic [IXW-1:0]    rd_idx,
  output logic [CW-1:0]     rd_cnt,
  output logic [SPW-1:0]    rd_span,
  output logic [CACHE*IW-1:0] rd_data
);
  logic [CW-1:0]    cnt  [DEPTH];
  logic [SPW-1:0]   span [DEPTH];
  logic [DEPTH-1:0] open;
  logic [IW-1:0]    data_mem [DEPTH][CACHE];

  logic          wr_ok;
  logic [SLW-1:0] wr_slot;
  assign wr_ok   = wr && open[wr_idx];
  assign wr_slot = SLW'(cnt[wr_idx]);

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[g]  <= '0;
        span[g] <= '0;
        open[g] <= 1'b0;
      end else if (init && init_idx == IXW'(g)) begin
        cnt[g]  <= '0;
        span[g] <= '0;
        open[g] <= 1'b1;
      end else begin
        if (wr_ok && wr_idx == IXW'(g)) begin
          cnt[g]  <= cnt[g] + CW'(1);
          span[g] <= span[g] + SPW'(wr_len);
          if (cnt[g] + CW'(1) == CW'(CACHE)) open[g] <= 1'b0;
        end
        if (close && close_idx == IXW'(g)) open[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) data_mem[wr_idx][wr_slot] <= wr_data;
  end

  assign rd_cnt  = cnt[rd_idx];
  assign rd_span = span[rd_idx];

  for (genvar j = 0; j < CACHE; j++) begin : g_slot
    assign rd_data[j*IW +: IW] = (CW'(j) < rd_cnt) ? data_mem[rd_idx][j] : '0;
  end
endmodule

// File: rtl/loop_track_unit.sv
`timescale 1ns/1ps
module loop_track_unit
  import loop_track_pkg::*;
#(
  parameter int AW    = 40,
  parameter int IW    = 32,
  parameter int LW    = 3,
  parameter int DEPTH = 4,
  parameter int CACHE = 2,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int IXW  = $clog2(DEPTH),
  localparam int CW   = $clog2(CACHE + 1),
  localparam int SPW  = LW + CW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2:0]          in_kind,
  input  logic [AW-1:0]       in_pc,
  input  logic [LW-1:0]       in_len,
  input  logic [IW-1:0]       in_instr,
  input  logic [AW-1:0]       in_end,
  output logic                out_valid,
  output logic [AW-1:0]       out_pc,
  output logic [IW-1:0]       out_instr,
  output logic [CW-1:0]       rpl_count,
  output logic [AW-1:0]       rpl_pc,
  output logic [CACHE*IW-1:0] rpl_instr,
  output logic                redir_valid,
  output logic [AW-1:0]       redir_pc,
  output logic                ovf_flag,
  output logic                udf_flag,
  output logic                brk_err
);
  logic k_norm, k_beg, k_back, k_exit, k_brk;
  assign k_norm = in_valid && (in_kind == LK_NORM);
  assign k_beg  = in_valid && (in_kind == LK_BEGIN || in_kind == LK_BEGIN_X);
  assign k_back = in_valid && (in_kind == LK_BACK);
  assign k_exit = in_valid && (in_kind == LK_EXIT);
  assign k_brk  = in_valid && (in_kind == LK_BREAK);

  logic [AW-1:0]  top_start, top_end;
  logic           top_has_end, full, empty;
  logic [PW-1:0]  stk_level;
  logic [IXW-1:0] top_idx, new_idx;
  logic           do_push, do_pop;

  assign do_push = k_beg && !full;
  assign do_pop  = (k_exit || k_brk) && !empty;

  loop_addr_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst),
    .push(do_push), .pop(do_pop),
    .push_start(in_pc + AW'(in_len)),
    .push_end(in_end),
    .push_has_end(in_kind == LK_BEGIN_X),
    .top_start(top_start), .top_end(top_end), .top_has_end(top_has_end),
    .level(stk_level), .top_idx(top_idx), .new_idx(new_idx),
    .full(full), .empty(empty)
  );

  logic [CW-1:0]       rd_cnt;
  logic [SPW-1:0]      rd_span;
  logic [CACHE*IW-1:0] rd_data;

  loop_instr_cache #(.IW(IW), .LW(LW), .DEPTH(DEPTH), .CACHE(CACHE)) u_cache (
    .clk(clk), .rst(rst),
    .init(do_push), .init_idx(new_idx),
    .close((k_beg || k_back || k_exit || k_brk) && !empty), .close_idx(top_idx),
    .wr(k_norm && !empty), .wr_idx(top_idx), .wr_data(in_instr), .wr_len(in_len),
    .rd_idx(top_idx),
    .rd_cnt(rd_cnt), .rd_span(rd_span), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    out_valid   <= 1'b0;
    out_pc      <= '0;
    out_instr   <= '0;
    rpl_count   <= '0;
    rpl_pc      <= '0;
    rpl_instr   <= '0;
    redir_valid <= 1'b0;
    redir_pc    <= '0;
    ovf_flag    <= 1'b0;
    udf_flag    <= 1'b0;
    brk_err     <= 1'b0;
    if (!rst) begin
      if (k_norm) begin
        out_valid <= 1'b1;
        out_pc    <= in_pc;
        out_instr <= in_instr;
      end
      if (k_beg && full) ovf_flag <= 1'b1;
      if ((k_back || k_exit || k_brk) && empty) udf_flag <= 1'b1;
      if (k_back && !empty) begin
        rpl_count   <= rd_cnt;
        rpl_pc      <= top_start;
        rpl_instr   <= rd_data;
        redir_valid <= 1'b1;
        redir_pc    <= top_start + AW'(rd_span);
      end
      if (k_brk && !empty) begin
        if (top_has_end) begin
          redir_valid <= 1'b1;
          redir_pc    <= top_end;
        end else begin
          brk_err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/loop_track_chk.sv
`timescale 1ns/1ps
module loop_track_chk #(
  parameter int DEPTH = 4,
  parameter int CACHE = 2,
  parameter int PW    = 3,
  parameter int CW    = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    in_kind,
  input logic          out_valid,
  input logic [CW-1:0] rpl_count,
  input logic          redir_valid,
  input logic          ovf_flag,
  input logic          udf_flag,
  input logic          brk_err,
  input logic [PW-1:0] lvl
);
  p_one_event_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, redir_valid, ovf_flag, udf_flag, brk_err}));

  p_replay_redirect_r5: assert property (@(posedge clk) disable iff (rst)
    (rpl_count != '0) |-> redir_valid);

  p_replay_bound_r4: assert property (@(posedge clk) disable iff (rst)
    rpl_count <= CW'(CACHE));

  p_overflow_full_r9: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> (lvl == PW'(DEPTH) && $past(lvl) == PW'(DEPTH)));

  p_underflow_empty_r10: assert property (@(posedge clk) disable iff (rst)
    udf_flag |-> (lvl == '0 && $past(lvl) == '0));

  p_break_pops_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 3'd5 && lvl != '0) |=> (lvl == $past(lvl) - PW'(1)));

  p_ctrl_not_forwarded_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind != 3'd0) |=> !out_valid);
endmodule

bind loop_track_unit loop_track_chk #(
  .DEPTH(DEPTH), .CACHE(CACHE), .PW(PW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
  .out_valid(out_valid), .rpl_count(rpl_count), .redir_valid(redir_valid),
  .ovf_flag(ovf_flag), .udf_flag(udf_flag), .brk_err(brk_err),
  .lvl(stk_level)
);

// File: tb/tb_loop_track_unit.sv
`timescale 1ns/1ps
module tb_loop_track_unit;
  localparam int AW = 40, IW = 32, LW = 3, DEPTH = 4, CACHE = 2;
  localparam int CW = $clog2(CACHE + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] in_kind = '0;
  logic [AW-1:0] in_pc = '0, in_end = '0;
  logic [LW-1:0] in_len = '0;
  logic [IW-1:0] in_instr = '0;
  logic out_valid, redir_valid, ovf_flag, udf_flag, brk_err;
  logic [AW-1:0] out_pc, rpl_pc, redir_pc;
  logic [IW-1:0] out_instr;
  logic [CW-1:0] rpl_count;
  logic [CACHE*IW-1:0] rpl_instr;

  always #10 clk = ~clk;

  loop_track_unit #(.AW(AW), .IW(IW), .LW(LW), .DEPTH(DEPTH), .CACHE(CACHE)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_pc(in_pc),
    .in_len(in_len), .in_instr(in_instr), .in_end(in_end),
    .out_valid(out_valid), .out_pc(out_pc), .out_instr(out_instr),
    .rpl_count(rpl_count), .rpl_pc(rpl_pc), .rpl_instr(rpl_instr),
    .redir_valid(redir_valid), .redir_pc(redir_pc),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag), .brk_err(brk_err)
  );

  typedef struct packed {
    logic ov; logic [AW-1:0] opc; logic [IW-1:0] oi;
    logic [CW-1:0] rc; logic [AW-1:0] rpc; logic [CACHE*IW-1:0] ri;
    logic rv; logic [AW-1:0] rdpc; logic ovf; logic udf; logic berr;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // requirement model of the loop stack
  logic [AW-1:0] m_start[DEPTH], m_end[DEPTH], m_span[DEPTH];
  logic [IW-1:0] m_dat[DEPTH][CACHE];
  bit m_has[DEPTH], m_open[DEPTH];
  int m_cnt[DEPTH];
  int m_lvl = 0;

  function automatic obs_t sample();
    return {out_valid, out_pc, out_instr, rpl_count, rpl_pc, rpl_instr,
            redir_valid, redir_pc, ovf_flag, udf_flag, brk_err};
  endfunction

  task automatic step(input logic [2:0] k, input logic [AW-1:0] pc,
                      input logic [LW-1:0] len, input logic [IW-1:0] ins,
                      input logic [AW-1:0] ea, input string tag);
    obs_t e;
    int t;
    e = '0;
    t = m_lvl - 1;
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_pc = pc; in_len = len; in_instr = ins; in_end = ea;
    if (k != 3'd0 && m_lvl > 0) m_open[t] = 1'b0;
    case (k)
      3'd0: begin
        e.ov = 1'b1; e.opc = pc; e.oi = ins;
        if (m_lvl > 0 && m_open[t]) begin
          m_dat[t][m_cnt[t]] = ins;
          m_cnt[t]++;
          m_span[t] += AW'(len);
          if (m_cnt[t] == CACHE) m_open[t] = 1'b0;
        end
      end
      3'd1, 3'd2: begin
        if (m_lvl == DEPTH) e.ovf = 1'b1;
        else begin
          m_start[m_lvl] = pc + AW'(len); m_end[m_lvl] = ea; m_has[m_lvl] = (k == 3'd2);
          m_cnt[m_lvl] = 0; m_span[m_lvl] = '0; m_open[m_lvl] = 1'b1;
          m_lvl++;
        end
      end
      3'd3: begin
        if (m_lvl == 0) e.udf = 1'b1;
        else begin
          e.rc = CW'(m_cnt[t]); e.rpc = m_start[t];
          for (int j = 0; j < CACHE; j++)
            if (j < m_cnt[t]) e.ri[j*IW +: IW] = m_dat[t][j];
          e.rv = 1'b1; e.rdpc = m_start[t] + m_span[t];
        end
      end
      3'd4: begin
        if (m_lvl == 0) e.udf = 1'b1; else m_lvl--;
      end
      default: begin
        if (m_lvl == 0) e.udf = 1'b1;
        else begin
          if (m_has[t]) begin e.rv = 1'b1; e.rdpc = m_end[t]; end
          else e.berr = 1'b1;
          m_lvl--;
        end
      end
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    in_valid = 1'b0; in_kind = '0;
    exp_q.push_back('0);
    tag_q.push_back(tag);
  endtask

  task automatic direct(input string tag);
    obs_t a;
    a = sample();
    checks++;
    if (a !== '0) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, a, obs_t'('0));
    end
  endtask

  // monitor: results of the input driven at a negedge are visible after the next posedge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        obs_t e, a;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        a = sample();
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", tg, a, e);
        end
      end
    end
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    direct("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    direct("R1 after reset");

    // R2: plain forwarding, no loop active
    step(3'd0, 40'h10, 3'd4, 32'hA0A0_0001, '0, "R2 pass-through");
    step(3'd0, 40'h14, 3'd2, 32'hA0A0_0002, '0, "R2 pass-through");
    idle("R2 idle zero");

    // R10: underflow on empty stack
    step(3'd3, 40'h20, 3'd1, '0, '0, "R10 back on empty");
    step(3'd4, 40'h21, 3'd1, '0, '0, "R10 exit on empty");
    step(3'd5, 40'h22, 3'd1, '0, '0, "R10 break on empty");

    // R3/R4/R5/R8: body longer than the capture window
    step(3'd1, 40'h100, 3'd2, 32'hB000_0000, '0, "R3 begin not forwarded");
    step(3'd0, 40'h102, 3'd3, 32'h1111_1111, '0, "R4 capture slot0");
    step(3'd0, 40'h105, 3'd1, 32'h2222_2222, '0, "R4 capture slot1");
    step(3'd0, 40'h106, 3'd2, 32'h3333_3333, '0, "R4 beyond window");
    step(3'd3, 40'h108, 3'd1, '0, '0, "R5 replay two");
    step(3'd0, 40'h106, 3'd2, 32'h3333_3333, '0, "R4 no recapture");
    step(3'd3, 40'h108, 3'd1, '0, '0, "R5 replay again");
    step(3'd4, 40'h109, 3'd1, '0, '0, "R8 exit no redirect");

    // R5/R6: single-instruction body, break with exit address
    step(3'd2, 40'h200, 3'd5, '0, 40'h300, "R3 begin with end");
    step(3'd0, 40'h205, 3'd4, 32'h4444_4444, '0, "R4 one captured");
    step(3'd3, 40'h209, 3'd1, '0, '0, "R5 partial replay");
    step(3'd5, 40'h20A, 3'd1, '0, '0, "R6 break redirect");

    // R11/R7: nesting
    step(3'd1, 40'h400, 3'd1, '0, '0, "R3 outer begin");
    step(3'd0, 40'h401, 3'd2, 32'hC1C1_C1C1, '0, "R4 outer capture");
    step(3'd1, 40'h403, 3'd1, '0, '0, "R3 inner begin");
    step(3'd0, 40'h404, 3'd1, 32'hD1D1_D1D1, '0, "R4 inner capture");
    step(3'd0, 40'h405, 3'd2, 32'hD2D2_D2D2, '0, "R4 inner capture");
    step(3'd0, 40'h407, 3'd1, 32'hD3D3_D3D3, '0, "R4 inner beyond");
    step(3'd3, 40'h408, 3'd1, '0, '0, "R5 inner replay");
    step(3'd5, 40'h409, 3'd1, '0, '0, "R7 break without end");
    step(3'd3, 40'h40A, 3'd1, '0, '0, "R11 outer replay intact");
    step(3'd4, 40'h40B, 3'd1, '0, '0, "R8 outer exit");

    // R9: overflow
    for (int i = 0; i < DEPTH; i++) begin
      step(3'd1, 40'h800 + 40'(i * 16), 3'd1, '0, '0, "R9 fill");
      step(3'd0, 40'h801 + 40'(i * 16), 3'd3, 32'hE000_0000 + 32'(i), '0, "R9 fill body");
    end
    step(3'd2, 40'h900, 3'd1, '0, 40'h950, "R9 overflow flag");
    step(3'd3, 40'h901, 3'd1, '0, '0, "R9 top unchanged");
    for (int i = 0; i < DEPTH; i++) step(3'd4, 40'hA00, 3'd1, '0, '0, "R8 drain");
    step(3'd4, 40'hA01, 3'd1, '0, '0, "R10 exit past empty");

    // R3/R6: 40-bit address range
    step(3'd2, 40'hFF_FFFF_FFF0, 3'd4, '0, 40'hFF_FFFF_FFFC, "R3 high address");
    step(3'd0, 40'hFF_FFFF_FFF4, 3'd5, 32'hF5F5_F5F5, '0, "R4 high capture");
    step(3'd3, 40'hFF_FFFF_FFF9, 3'd1, '0, '0, "R5 high redirect");
    step(3'd5, 40'hFF_FFFF_FFFA, 3'd1, '0, '0, "R6 high break");
    idle("R12 quiet");
    idle("R12 quiet");

    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule